// File: doc/BRIEF.md
# Decode-Stage Conditional Branch Resolver

This block decides conditional branches while the branch sits in the decode stage of a five-stage pipelined 32-bit integer core. Resolving there, and not in execute, shortens the penalty of a taken branch to a single wrong-path fetch slot. The resolver receives the decoded instruction word, the program counter of that instruction, and the two source operand values. Those operands have already passed through the core's forwarding selection. It also receives a flag that says the decode slot holds a real instruction.

Two branch kinds are recognised. The first is taken when the two operands are equal. The second is taken when the first operand is greater than or equal to the second, using signed two's-complement order. All outputs are combinational within the decode cycle:
- a taken flag;
- the redirect target, which is the branch's own PC plus its sign-extended immediate;
- the sequential PC, which is PC plus 4;
- a request to turn the instruction now in fetch into a bubble.

The fetch PC register outside the block loads either the target or the sequential PC on the next clock edge.

Top module: `brres_unit`

## Requirements
- R1: With opcode field inst[6:0] = 7'b1100011 and funct3 field inst[14:12] = 3'b000 (equality kind), taken_o is 1 exactly when all 32 bits of src_a_i equal src_b_i, while valid_i is 1.
- R2: With opcode 7'b1100011 and funct3 3'b101 (greater-or-equal kind), taken_o is 1 exactly when src_a_i is greater than or equal to src_b_i, both read as signed two's-complement numbers, while valid_i is 1.
- R3: target_o equals pc_i plus the 13-bit immediate {inst[31], inst[7], inst[30:25], inst[11:8], 1'b0} sign-extended to 32 bits, with the sum wrapping modulo 2^32.
- R4: seq_pc_o always equals pc_i + 4 (modulo 2^32), whatever the other inputs are.
- R5: flush_o is 1 in exactly the cycles in which taken_o is 1.
- R6: While valid_i is 0, taken_o and flush_o are both 0, even if the instruction word and operands would otherwise give a taken branch.
- R7: Any opcode other than 7'b1100011, or funct3 other than 3'b000 or 3'b101, gives taken_o = 0 and flush_o = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| inst_i | input | 32 | Instruction word held in the decode stage |
| pc_i | input | 32 | PC of the instruction in decode |
| src_a_i | input | 32 | First source operand, after forwarding selection |
| src_b_i | input | 32 | Second source operand, after forwarding selection |
| valid_i | input | 1 | Decode slot holds a real instruction |
| taken_o | output | 1 | Conditional branch in decode is taken |
| target_o | output | 32 | Redirect PC for a taken branch |
| seq_pc_o | output | 32 | Next sequential PC |
| flush_o | output | 1 | Turn the instruction in fetch into a bubble |

## Verification
The embedded assertions check some relations whenever the inputs are known:
- an empty decode slot never redirects;
- flush agrees with taken;
- a non-branch opcode stays quiet;
- the sequential PC is exactly four ahead;
- the target keeps the parity of the PC;
- the comparator never reports equality without greater-or-equal.

Some behaviour can only be shown by the bench's directed scenarios, with expected values worked out independently:
- the signed ordering across the sign boundary;
- a miscompare confined to bit 31;
- the bit scatter of the immediate at its extreme offsets;
- PC wrap-around;
- the rejection of each unused funct3 code.

// File: rtl/brres_pkg.sv
package brres_pkg;

    localparam logic [6:0] OPC_COND_BR = 7'b1100011;
    localparam logic [2:0] F3_BR_EQ    = 3'b000;
    localparam logic [2:0] F3_BR_GE    = 3'b101;

    typedef enum logic [1:0] {
        BR_NONE = 2'd0,
        BR_EQ   = 2'd1,
        BR_GE   = 2'd2
    } br_kind_e;

    typedef struct packed {
        logic taken;
        logic flush;
    } redirect_t;

endpackage

// File: rtl/brres_decode.sv
module brres_decode
    import brres_pkg::*;
#(
    parameter int ILEN = 32,
    parameter int XLEN = 32
) (
    input  logic [ILEN-1:0] inst_i,
    output br_kind_e        kind_o,
    output logic [XLEN-1:0] imm_o
);
    localparam int IMM_W = 13;
    localparam int EXT_W = XLEN - IMM_W;

    typedef struct packed {
        br_kind_e         kind;
        logic [XLEN-1:0]  imm;
    } dec_t;

    dec_t dec_d;
    logic [IMM_W-1:0] imm_raw;

    logic unused_fields;
    assign unused_fields = ^inst_i[24:15];

    always_comb begin
        imm_raw   = {inst_i[31], inst_i[7], inst_i[30:25], inst_i[11:8], 1'b0};
        dec_d     = '0;
        dec_d.imm = {{EXT_W{imm_raw[IMM_W-1]}}, imm_raw};
        dec_d.kind = BR_NONE;
        if (inst_i[6:0] == OPC_COND_BR) begin
            unique case (inst_i[14:12])
                F3_BR_EQ: dec_d.kind = BR_EQ;
                F3_BR_GE: dec_d.kind = BR_GE;
                default:  dec_d.kind = BR_NONE;
            endcase
        end
    end

    assign kind_o = dec_d.kind;
    assign imm_o  = dec_d.imm;

endmodule

// File: rtl/brres_compare.sv
module brres_compare #(
    parameter int XLEN       = 32,
    parameter bit GE_VIA_SUB = 1'b1
) (
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    output logic            eq_o,
    output logic            ge_o
);
    localparam int DW = XLEN + 1;

    logic eq_d;
    logic ge_d;

    always_comb begin
        eq_d = (a_i == b_i);
    end

    generate
        if (GE_VIA_SUB) begin : g_sub
            logic [DW-1:0] diff_d;
            always_comb begin
                diff_d = {a_i[XLEN-1], a_i} - {b_i[XLEN-1], b_i};
                ge_d   = ~diff_d[DW-1];
            end
        end else begin : g_cmp
            always_comb begin
                ge_d = ($signed(a_i) >= $signed(b_i));
            end
        end
    endgenerate

    assign eq_o = eq_d;
    assign ge_o = ge_d;

    // Equality must always imply greater-or-equal (R2 consistency)
    always_comb begin
        if (!$isunknown({a_i, b_i})) begin
            assert_eq_implies_ge_R2: assert (!eq_o || ge_o)
                else $error("comparator: equal operands but ge low");
        end
    end

endmodule

// File: rtl/brres_target.sv
module brres_target #(
    parameter int XLEN    = 32,
    parameter int PC_STEP = 4
) (
    input  logic [XLEN-1:0] pc_i,
    input  logic [XLEN-1:0] imm_i,
    output logic [XLEN-1:0] target_o,
    output logic [XLEN-1:0] seq_o
);
    localparam logic [XLEN-1:0] STEP = XLEN'(PC_STEP);

    typedef struct packed {
        logic [XLEN-1:0] target;
        logic [XLEN-1:0] seq;
    } addr_t;

    addr_t addr_d;

    always_comb begin
        addr_d.target = pc_i + imm_i;
        addr_d.seq    = pc_i + STEP;
    end

    assign target_o = addr_d.target;
    assign seq_o    = addr_d.seq;

endmodule

// File: rtl/brres_unit.sv
module brres_unit
    import brres_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int ILEN       = 32,
    parameter int PC_STEP    = 4,
    parameter bit GE_VIA_SUB = 1'b1
) (
    input  logic [ILEN-1:0] inst_i,
    input  logic [XLEN-1:0] pc_i,
    input  logic [XLEN-1:0] src_a_i,
    input  logic [XLEN-1:0] src_b_i,
    input  logic            valid_i,
    output logic            taken_o,
    output logic [XLEN-1:0] target_o,
    output logic [XLEN-1:0] seq_pc_o,
    output logic            flush_o
);
    br_kind_e        kind;
    logic [XLEN-1:0] imm;
    logic            eq;
    logic            ge;
    redirect_t       res_d;

    brres_decode #(
        .ILEN (ILEN),
        .XLEN (XLEN)
    ) u_decode (
        .inst_i (inst_i),
        .kind_o (kind),
        .imm_o  (imm)
    );

    brres_compare #(
        .XLEN       (XLEN),
        .GE_VIA_SUB (GE_VIA_SUB)
    ) u_compare (
        .a_i  (src_a_i),
        .b_i  (src_b_i),
        .eq_o (eq),
        .ge_o (ge)
    );

    brres_target #(
        .XLEN    (XLEN),
        .PC_STEP (PC_STEP)
    ) u_target (
        .pc_i     (pc_i),
        .imm_i    (imm),
        .target_o (target_o),
        .seq_o    (seq_pc_o)
    );

    always_comb begin
        logic cond;
        unique case (kind)
            BR_EQ:   cond = eq;
            BR_GE:   cond = ge;
            default: cond = 1'b0;
        endcase
        res_d.taken = valid_i & cond;
        res_d.flush = valid_i & (kind != BR_NONE) & cond;
    end

    assign taken_o = res_d.taken;
    assign flush_o = res_d.flush;

    // Port-level invariants, checked whenever inputs are known
    always_comb begin
        if (!$isunknown({inst_i, pc_i, src_a_i, src_b_i, valid_i})) begin
            assert_idle_no_redirect_R6: assert (valid_i || (!taken_o && !flush_o))
                else $error("redirect with empty decode slot");
            assert_flush_tracks_taken_R5: assert (flush_o == taken_o)
                else $error("flush and taken disagree");
            assert_foreign_opcode_quiet_R7: assert ((inst_i[6:0] == OPC_COND_BR) || !taken_o)
                else $error("non-branch opcode taken");
            assert_seq_step_R4: assert ((seq_pc_o - pc_i) == XLEN'(PC_STEP))
                else $error("sequential PC step wrong");
            assert_target_parity_R3: assert (target_o[0] == pc_i[0])
                else $error("target lost PC parity");
        end
    end

endmodule

// File: tb/brres_unit_bench.sv
module brres_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic [31:0] inst_i = '0;
    logic [31:0] pc_i = '0;
    logic [31:0] src_a_i = '0;
    logic [31:0] src_b_i = '0;
    logic        valid_i = 1'b0;
    logic        taken_o;
    logic [31:0] target_o;
    logic [31:0] seq_pc_o;
    logic        flush_o;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    brres_unit u_brres_unit (
        .inst_i   (inst_i),
        .pc_i     (pc_i),
        .src_a_i  (src_a_i),
        .src_b_i  (src_b_i),
        .valid_i  (valid_i),
        .taken_o  (taken_o),
        .target_o (target_o),
        .seq_pc_o (seq_pc_o),
        .flush_o  (flush_o)
    );

    function automatic logic [31:0] enc(input logic [6:0] opc, input logic [2:0] f3,
                                        input int off);
        logic [12:0] o;
        o = off[12:0];
        return {o[12], o[10:5], 5'd2, 5'd1, f3, o[4:1], o[11], opc};
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic apply(input logic [31:0] inst, input logic [31:0] pc,
                         input logic [31:0] a, input logic [31:0] b, input logic v);
        @(negedge clk);
        inst_i = inst; pc_i = pc; src_a_i = a; src_b_i = b; valid_i = v;
        @(posedge clk);
        #1;
    endtask

    task automatic expect_redirect(input string req, input logic exp_taken);
        check(req, {31'd0, taken_o}, {31'd0, exp_taken});
        check({req, "/R5"}, {31'd0, flush_o}, {31'd0, exp_taken});
    endtask

    task automatic t_reset_state;
        apply('0, '0, '0, '0, 1'b0);
        expect_redirect("R6 idle start", 1'b0);
        check("R4 idle seq", seq_pc_o, 32'd4);
    endtask

    task automatic t_equal_branch;
        apply(enc(7'h63, 3'b000, 16), 32'h100, 32'h1234, 32'h1234, 1'b1);
        expect_redirect("R1 equal", 1'b1);
        check("R3 eq target", target_o, 32'h110);
        apply(enc(7'h63, 3'b000, 16), 32'h100, 32'h8000_1234, 32'h0000_1234, 1'b1);
        expect_redirect("R1 bit31 differs", 1'b0);
        apply(enc(7'h63, 3'b000, 16), 32'h100, 32'h1235, 32'h1234, 1'b1);
        expect_redirect("R1 bit0 differs", 1'b0);
    endtask

    task automatic t_ge_branch;
        apply(enc(7'h63, 3'b101, -8), 32'h200, 32'd5, 32'd5, 1'b1);
        expect_redirect("R2 equal operands", 1'b1);
        check("R3 back target", target_o, 32'h1F8);
        apply(enc(7'h63, 3'b101, 8), 32'h200, 32'hFFFF_FFFF, 32'd0, 1'b1);
        expect_redirect("R2 -1 vs 0", 1'b0);
        apply(enc(7'h63, 3'b101, 8), 32'h200, 32'd0, 32'hFFFF_FFFF, 1'b1);
        expect_redirect("R2 0 vs -1", 1'b1);
        apply(enc(7'h63, 3'b101, 8), 32'h200, 32'h7FFF_FFFF, 32'h8000_0000, 1'b1);
        expect_redirect("R2 max vs min", 1'b1);
        apply(enc(7'h63, 3'b101, 8), 32'h200, 32'h8000_0000, 32'h7FFF_FFFF, 1'b1);
        expect_redirect("R2 min vs max", 1'b0);
        apply(enc(7'h63, 3'b101, 8), 32'h200, 32'd3, 32'd9, 1'b1);
        expect_redirect("R2 small less", 1'b0);
    endtask

    task automatic t_immediate_extremes;
        apply(enc(7'h63, 3'b000, 4094), 32'h1000, '0, '0, 1'b1);
        check("R3 max fwd", target_o, 32'h1000 + 32'd4094);
        apply(enc(7'h63, 3'b000, -4096), 32'h2000, '0, '0, 1'b1);
        check("R3 max back", target_o, 32'h1000);
        apply(enc(7'h63, 3'b000, 2048), 32'h0, '0, '0, 1'b1);
        check("R3 bit11 only", target_o, 32'h800);
        apply(enc(7'h63, 3'b000, -2), 32'h0, '0, '0, 1'b1);
        check("R3 wrap below zero", target_o, 32'hFFFF_FFFE);
    endtask

    task automatic t_sequential;
        apply(enc(7'h63, 3'b000, 16), 32'hFFFF_FFFC, 32'd1, 32'd2, 1'b1);
        check("R4 wrap", seq_pc_o, 32'h0);
        expect_redirect("R1 not taken seq", 1'b0);
        apply(32'h0000_0013, 32'h0000_0ABC, 32'd1, 32'd1, 1'b1);
        check("R4 non-branch", seq_pc_o, 32'h0000_0AC0);
    endtask

    task automatic t_invalid_slot;
        apply(enc(7'h63, 3'b000, 16), 32'h300, 32'd7, 32'd7, 1'b0);
        expect_redirect("R6 eq bubble", 1'b0);
        apply(enc(7'h63, 3'b101, 16), 32'h300, 32'd9, 32'd1, 1'b0);
        expect_redirect("R6 ge bubble", 1'b0);
    endtask

    task automatic t_other_codes;
        for (int f = 0; f < 8; f++) begin
            if (f != 0 && f != 5) begin
                apply(enc(7'h63, 3'(f), 16), 32'h400, 32'd4, 32'd4, 1'b1);
                expect_redirect($sformatf("R7 funct3 %0d", f), 1'b0);
            end
        end
        apply(enc(7'h33, 3'b000, 16), 32'h400, 32'd4, 32'd4, 1'b1);
        expect_redirect("R7 reg-reg opcode", 1'b0);
        apply(enc(7'h67, 3'b000, 16), 32'h400, 32'd4, 32'd4, 1'b1);
        expect_redirect("R7 jump opcode", 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset_state();
        t_equal_branch();
        t_ge_branch();
        t_immediate_extremes();
        t_sequential();
        t_invalid_slot();
        t_other_codes();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule